// File: doc/BRIEF.md
# Constant-Coefficient Multiplier with Signed-Digit Recoding

This block multiplies a stream of signed samples by a fixed coefficient that is chosen when the design is built. It does not use a general multiplier array. When the design is elaborated, a package function rewrites the coefficient in signed-digit form, where each digit is -1, 0 or +1 and no two neighbouring digits are both nonzero. Each nonzero digit then becomes one copy of the sample shifted left by that digit's position. A +1 digit adds its copy and a -1 digit subtracts it. A run of consecutive ones therefore costs one addition and one subtraction, not one adder per bit.

The coefficient needs no logic while the block runs. A coefficient of zero builds no adders at all, and the output is a constant zero.

The product has the full width: input width plus coefficient width plus one bit, so it cannot overflow. It passes through one output register, which loads only when the input valid flag is high. The output valid flag is the input valid flag delayed by one clock.

Top module: `csd_const_mult`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `out_prod` equals the signed value of `in_sample` multiplied by the unsigned coefficient `COEFF`. The product is exact in two's complement over the full `PW = IW + CW + 1` bits.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high.
- R3: After a cycle with `in_valid` low, `out_prod` keeps its previous value, whatever `in_sample` was.
- R4: While `rst_n` is low, `out_valid` is 0 and `out_prod` is 0.
- R5: With `COEFF` equal to 0, `out_prod` stays 0 for every input, valid or not.
- R6: The most negative input (-2^(IW-1)) and the most positive input (2^(IW-1)-1) give exact products with no overflow. At IW=8 and a coefficient of 111, these products are -14208 and 14097.
- R7: A coefficient made entirely of ones, such as 255 (recoded as 256 - 1), gives exact products for every input.
- R8: A coefficient with alternating ones, such as 85 (binary 0101_0101), gives exact products for every input. This is the densest pattern, with a nonzero digit at every other position.
- R9: A coefficient of binary 1001 (9) gives the sample plus the sample shifted left by three, for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_sample` as a sample to multiply |
| in_sample | input | IW | Signed two's-complement sample |
| out_valid | output | 1 | Marks `out_prod` as the product of the sample from the previous cycle |
| out_prod | output | PW | Signed full-width product, PW = IW + CW + 1 |

## Verification
The assertions assume that the reset is applied before the first sample and that `in_valid` and `in_sample` are stable around each rising clock edge. The bench meets both conditions: it holds reset for several cycles and changes its inputs only on falling edges.

The assertions do not restrict the input values. The bench therefore sweeps every 8-bit sample, including both extreme values, through several instances that differ only in their coefficient: the worked example 111, binary 1001, all ones, alternating ones, and zero. Idle cycles are mixed in, and during these `in_sample` is changed to a value never multiplied, so the bench can confirm that the held output does not follow it.

// File: rtl/csdm_pkg.sv
package csdm_pkg;

   localparam int MAXW = 63;
   localparam int MAXD = MAXW + 1;

   // Recodes c (n bits, unsigned) into non-adjacent signed digits.
   // Returns the mask of +1 digits, or of -1 digits when want_neg is set.
   function automatic logic [MAXD-1:0] csd_mask(input logic [MAXW-1:0] c,
                                               input int n,
                                               input bit want_neg);
      logic [MAXD-1:0] m;
      logic carry;
      logic cur;
      logic nxt;
      m = '0;
      carry = 1'b0;
      for (int i = 0; i <= n; i++) begin
         cur = (i < n) ? c[i] : 1'b0;
         nxt = (i + 1 < n) ? c[i+1] : 1'b0;
         if (cur ^ carry) begin
            if (nxt) begin
               if (want_neg) m[i] = 1'b1;
               carry = 1'b1;
            end else begin
               if (!want_neg) m[i] = 1'b1;
               carry = 1'b0;
            end
         end else begin
            carry = cur & carry;
         end
      end
      return m;
   endfunction

   // Value of a digit set given as plus and minus masks.
   function automatic longint csd_value(input logic [MAXD-1:0] p,
                                        input logic [MAXD-1:0] q);
      longint v;
      v = 0;
      for (int i = 0; i < MAXD; i++) begin
         if (p[i]) v = v + (longint'(1) << i);
         if (q[i]) v = v - (longint'(1) << i);
      end
      return v;
   endfunction

endpackage

// File: rtl/csdm_term.sv
module csdm_term #(
   parameter int IW    = 16,
   parameter int PW    = 29,
   parameter int SHIFT = 0,
   parameter bit NEG   = 1'b0
) (
   input  logic signed [IW-1:0] x,
   output logic signed [PW-1:0] term
);

   logic signed [PW-1:0] x_ext;
   logic signed [PW-1:0] x_shl;

   always_comb begin
      x_ext = PW'(x);
      x_shl = x_ext <<< SHIFT;
   end

   generate
      if (NEG) begin : g_sub
         assign term = -x_shl;
      end else begin : g_add
         assign term = x_shl;
      end
   endgenerate

endmodule

// File: rtl/csdm_chain.sv
module csdm_chain #(
   parameter int IW = 16,
   parameter int CW = 12,
   parameter int PW = IW + CW + 1,
   parameter logic [CW:0] POS_MASK = '0,
   parameter logic [CW:0] NEG_MASK = '0
) (
   input  logic signed [IW-1:0] x,
   output logic signed [PW-1:0] sum
);

   localparam int DW = CW + 1;

   logic signed [PW-1:0] part [DW+1];

   assign part[0] = '0;

   generate
      for (genvar g = 0; g < DW; g++) begin : g_digit
         if (POS_MASK[g] || NEG_MASK[g]) begin : g_nz
            logic signed [PW-1:0] t;
            csdm_term #(
               .IW(IW), .PW(PW), .SHIFT(g), .NEG(NEG_MASK[g])
            ) u_term (
               .x(x),
               .term(t)
            );
            assign part[g+1] = part[g] + t;
         end else begin : g_z
            assign part[g+1] = part[g];
         end
      end
   endgenerate

   assign sum = part[DW];

endmodule

// File: rtl/csdm_stage.sv
module csdm_stage #(
   parameter int PW = 29
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          d_valid,
   input  logic [PW-1:0] d,
   output logic          q_valid,
   output logic [PW-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q       <= '0;
      end else begin
         q_valid <= d_valid;
         if (d_valid) q <= d;
      end
   end

endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult #(
   parameter int IW = 16,
   parameter int CW = 12,
   parameter logic [CW-1:0] COEFF = 12'd1775,
   parameter int PW = IW + CW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [IW-1:0] in_sample,
   output logic          out_valid,
   output logic [PW-1:0] out_prod
);

   localparam int DW = CW + 1;
   localparam logic [csdm_pkg::MAXD-1:0] POS_FULL =
      csdm_pkg::csd_mask(csdm_pkg::MAXW'(COEFF), CW, 1'b0);
   localparam logic [csdm_pkg::MAXD-1:0] NEG_FULL =
      csdm_pkg::csd_mask(csdm_pkg::MAXW'(COEFF), CW, 1'b1);
   localparam logic [DW-1:0] POS = POS_FULL[DW-1:0];
   localparam logic [DW-1:0] NEG = NEG_FULL[DW-1:0];
   localparam int NZ = $countones(POS | NEG);

   generate
      if (IW < 2 || CW < 1 || CW > csdm_pkg::MAXW - 1)
         $error("csd_const_mult: IW or CW out of range");
      if (PW != IW + CW + 1)
         $error("csd_const_mult: PW must equal IW + CW + 1");
      if (csdm_pkg::csd_value(POS_FULL, NEG_FULL) != longint'(COEFF))
         $error("csd_const_mult: recoded digits do not sum to COEFF");
      if (((POS | NEG) & ((POS | NEG) >> 1)) != '0)
         $error("csd_const_mult: adjacent nonzero digits");
      if (NZ > (DW + 1) / 2)
         $error("csd_const_mult: digit density above one half");
   endgenerate

   logic signed [PW-1:0] prod_comb;

   generate
      if (COEFF == '0) begin : g_zero
         assign prod_comb = '0;
      end else begin : g_net
         csdm_chain #(
            .IW(IW), .CW(CW), .PW(PW), .POS_MASK(POS), .NEG_MASK(NEG)
         ) u_chain (
            .x($signed(in_sample)),
            .sum(prod_comb)
         );
      end
   endgenerate

   csdm_stage #(.PW(PW)) u_stage (
      .clk(clk),
      .rst_n(rst_n),
      .d_valid(in_valid),
      .d(prod_comb),
      .q_valid(out_valid),
      .q(out_prod)
   );

   // Behavioural reference product for the checks below.
   logic signed [PW-1:0] ref_in;
   logic signed [PW-1:0] ref_coeff;
   logic signed [PW-1:0] ref_prod;
   always_comb begin
      ref_in    = PW'($signed(in_sample));
      ref_coeff = $signed(PW'(COEFF));
      ref_prod  = ref_in * ref_coeff;
   end

   assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_prod == $past(ref_prod)));

   assert_valid_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_prod));

   generate
      if (COEFF == '0) begin : g_zero_chk
         assert_zero_coeff_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_prod == '0);
      end
   endgenerate

endmodule

// File: tb/csd_const_mult_test.sv
`timescale 1ns/1ps
module csd_const_mult_test;

   localparam int IW = 8;
   localparam int CW = 8;
   localparam int PW = IW + CW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [IW-1:0] in_sample = '0;

   logic v_a, v_n, v_o, v_l, v_z;
   logic [PW-1:0] p_a, p_n, p_o, p_l, p_z;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   csd_const_mult #(.IW(IW), .CW(CW), .COEFF(8'd111), .PW(PW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(v_a), .out_prod(p_a));
   csd_const_mult #(.IW(IW), .CW(CW), .COEFF(8'd9), .PW(PW)) uut_nine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(v_n), .out_prod(p_n));
   csd_const_mult #(.IW(IW), .CW(CW), .COEFF(8'd255), .PW(PW)) uut_ones (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(v_o), .out_prod(p_o));
   csd_const_mult #(.IW(IW), .CW(CW), .COEFF(8'd85), .PW(PW)) uut_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(v_l), .out_prod(p_l));
   csd_const_mult #(.IW(IW), .CW(CW), .COEFF(8'd0), .PW(PW)) uut_zero (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(v_z), .out_prod(p_z));

   task automatic chk(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic longint sv(input logic [PW-1:0] v);
      return longint'($signed(v));
   endfunction

   task automatic check_all(input int x);
      chk("R2", longint'(v_a), 1);
      chk("R2", longint'(v_z), 1);
      chk((x == -128 || x == 127) ? "R6" : "R1", sv(p_a), longint'(x) * 111);
      chk("R9", sv(p_n), longint'(x) + (longint'(x) * 8));
      chk("R7", sv(p_o), longint'(x) * 256 - longint'(x));
      chk("R8", sv(p_l), longint'(x) * 85);
      chk("R5", sv(p_z), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
      $finish;
   end

   initial begin
      int last_x;
      repeat (3) @(negedge clk);
      chk("R4", longint'(v_a), 0);
      chk("R4", sv(p_a), 0);
      chk("R4", sv(p_o), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R6 R7 R8 R9 R5: full sweep, back to back
      last_x = 0;
      for (int x = -128; x <= 127; x++) begin
         @(negedge clk);
         if (x != -128) check_all(last_x);
         in_valid  = 1'b1;
         in_sample = IW'(x);
         last_x = x;
      end
      @(negedge clk);
      check_all(last_x);

      // R3 and R2: idle cycles with a changing sample
      for (int k = 0; k < 4; k++) begin
         in_valid  = 1'b0;
         in_sample = IW'(-55 + k * 31);
         @(negedge clk);
         chk("R2", longint'(v_a), 0);
         chk("R3", sv(p_a), longint'(last_x) * 111);
         chk("R3", sv(p_l), longint'(last_x) * 85);
      end

      // Sparse valid pattern mixing extremes
      for (int x = -128; x <= 127; x += 17) begin
         in_valid  = 1'b1;
         in_sample = IW'(x);
         @(negedge clk);
         check_all(x);
         in_valid  = 1'b0;
         in_sample = IW'(~x);
         @(negedge clk);
         chk("R2", longint'(v_n), 0);
         chk("R3", sv(p_n), longint'(x) * 9);
         chk("R5", sv(p_z), 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule